// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller

This controller sequences whole-array copies between a shadow RAM and its nonvolatile backing array. A copy in either direction walks an address counter through every location and emits one transfer strobe per location. A programming or settling hold follows the walk, and its length is set in clock ticks for each direction. Three events start a copy. The first is a recall that runs after any reset or power-up. The second is a host request, either a software store or a recall. The third is a power-fail store, which runs only when the automatic-store latch has been armed.

For the whole of a copy, and while a power-on recall is still owed, the busy output holds off all other functions. While the lockout input reports a supply too low to operate, busy also stays high and no copy may begin. An active-low status output follows the low-supply comparator one clock later. It can be wired together with other such outputs to interrupt a host. The analog comparators are outside the block and feed it as synchronous digital flags.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: In reset, busy reads 1, status_n reads 1, and xfer_stb and done read 0. After reset releases, a recall (xfer_dir = 0) starts at the first clock edge, and busy stays high until that recall ends.
- R2: During a copy, xfer_stb is high for exactly 2^ADDR_W consecutive cycles. xfer_addr starts at 0 and rises by 1 each cycle, and xfer_dir holds steady.
- R3: Busy stays high for exactly 2^ADDR_W + RECALL_HOLD cycles for a recall and 2^ADDR_W + STORE_HOLD cycles for a store. Done is a one-cycle pulse in the first cycle with busy low.
- R4: A store_req pulse while idle starts a store (xfer_dir = 1), with the first strobe in the cycle after the request.
- R5: A recall_req pulse while idle starts a recall (xfer_dir = 0), with the first strobe in the cycle after the request.
- R6: When supply_low is high and the latch is armed by an arm_set pulse, a store starts. Only one store runs per low-supply episode. An arm_clr pulse disarms the latch, after which supply_low starts nothing.
- R7: status_n equals the inverse of supply_low one cycle earlier, whether or not the latch is armed.
- R8: While lockout is high, busy is high one cycle later and no copy starts. Requests made during lockout are not remembered, but a pending power-on recall runs as soon as lockout clears.
- R9: store_req, recall_req and arm_set that arrive during a copy are ignored: nothing is queued and the latch stays unarmed.
- R10: A pwr_up_rst pulse disarms the latch and causes a recall to start.
- R11: When store_req and recall_req arrive together while idle, the store wins. The full order of precedence is power-on recall, power-fail store, software store, host recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, treated as a power-up |
| pwr_up_rst | input | 1 | Power-up reset comparator flag; owes a recall and disarms |
| supply_low | input | 1 | Supply below the automatic-store threshold |
| lockout | input | 1 | Supply at or below the lockout level |
| store_req | input | 1 | Software store command pulse |
| recall_req | input | 1 | Host recall request pulse |
| arm_set | input | 1 | Arm the automatic-store latch |
| arm_clr | input | 1 | Disarm the automatic-store latch (wins over arm_set) |
| busy | output | 1 | Copy running, recall owed, or locked out |
| status_n | output | 1 | Active-low low-supply status |
| xfer_stb | output | 1 | One-word transfer strobe |
| xfer_addr | output | ADDR_W | Word address of the current strobe |
| xfer_dir | output | 1 | 0 = nonvolatile to RAM, 1 = RAM to nonvolatile |
| done | output | 1 | One-cycle end-of-copy pulse |

## Verification
A trigger sampled at one clock edge makes the first strobe, address 0 and busy visible after that same edge. For that reason the bench drives each trigger on a falling edge and reads the outputs on the next falling edge. The bench then counts falling edges with busy high and expects 2^ADDR_W plus the hold for that direction. On the first falling edge with busy low it expects done, and one edge later it expects done to be low again. Lockout and status_n act after a single register, so they are checked one falling edge after their input changes. A pulse on pwr_up_rst takes two edges to produce a strobe: one to mark the recall as owed and one to start it.

// File: rtl/nvx_pkg.sv
package nvx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_HOLD = 2'd2
  } nvx_state_e;

  typedef enum logic {
    DIR_RECALL = 1'b0,
    DIR_STORE  = 1'b1
  } nvx_dir_e;
endpackage

// File: rtl/nvx_arbiter.sv
module nvx_arbiter
  import nvx_pkg::*;
(
  input  logic     allow_i,
  input  logic     por_pend_i,
  input  logic     pf_trig_i,
  input  logic     sw_store_i,
  input  logic     host_recall_i,
  output logic     start_o,
  output nvx_dir_e dir_o,
  output logic     take_por_o,
  output logic     take_pf_o
);
  // Fixed precedence: owed recall, power-fail store, software store, host recall.
  always_comb begin
    start_o    = 1'b0;
    dir_o      = DIR_RECALL;
    take_por_o = 1'b0;
    take_pf_o  = 1'b0;
    if (allow_i) begin
      if (por_pend_i) begin
        start_o    = 1'b1;
        take_por_o = 1'b1;
      end else if (pf_trig_i) begin
        start_o   = 1'b1;
        dir_o     = DIR_STORE;
        take_pf_o = 1'b1;
      end else if (sw_store_i) begin
        start_o = 1'b1;
        dir_o   = DIR_STORE;
      end else if (host_recall_i) begin
        start_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvx_walker.sv
module nvx_walker #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_o  <= 1'b0;
      addr_o <= '0;
    end else if (start_i) begin
      stb_o  <= 1'b1;
      addr_o <= '0;
    end else if (stb_o) begin
      if (addr_o == LAST) stb_o  <= 1'b0;
      else                addr_o <= addr_o + 1'b1;
    end
  end

  assign wrap_o = stb_o && (addr_o == LAST);
endmodule

// File: rtl/nvx_hold_timer.sv
module nvx_hold_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nvx_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int RECALL_HOLD = 64,
  parameter int STORE_HOLD  = 3000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_up_rst,
  input  logic              supply_low,
  input  logic              lockout,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              arm_set,
  input  logic              arm_clr,
  output logic              busy,
  output logic              status_n,
  output logic              xfer_stb,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              xfer_dir,
  output logic              done
);
  localparam int HOLD_MAX = (STORE_HOLD > RECALL_HOLD) ? STORE_HOLD : RECALL_HOLD;
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);
  localparam logic [CNT_W-1:0] LIM_RECALL = CNT_W'(RECALL_HOLD);
  localparam logic [CNT_W-1:0] LIM_STORE  = CNT_W'(STORE_HOLD);

  nvx_state_e st_q, st_nxt;
  nvx_dir_e   dir_q, sel_dir;
  logic       por_pend_q, pend_nxt;
  logic       armed_q, pf_done_q;
  logic       allow, start, take_por, take_pf, pf_trig;
  logic       wrap, expire;

  assign allow   = (st_q == ST_IDLE) && !lockout;
  assign pf_trig = armed_q && supply_low && !pf_done_q;

  nvx_arbiter u_arb (
    .allow_i       (allow),
    .por_pend_i    (por_pend_q),
    .pf_trig_i     (pf_trig),
    .sw_store_i    (store_req),
    .host_recall_i (recall_req),
    .start_o       (start),
    .dir_o         (sel_dir),
    .take_por_o    (take_por),
    .take_pf_o     (take_pf)
  );

  nvx_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .stb_o   (xfer_stb),
    .addr_o  (xfer_addr),
    .wrap_o  (wrap)
  );

  nvx_hold_timer #(.CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (start),
    .run_i    (st_q == ST_HOLD),
    .limit_i  ((dir_q == DIR_STORE) ? LIM_STORE : LIM_RECALL),
    .expire_o (expire)
  );

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_IDLE: if (start)  st_nxt = ST_COPY;
      ST_COPY: if (wrap)   st_nxt = ST_HOLD;
      ST_HOLD: if (expire) st_nxt = ST_IDLE;
      default:             st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_nxt = por_pend_q;
    if (take_por)   pend_nxt = 1'b0;
    if (pwr_up_rst) pend_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      dir_q      <= DIR_RECALL;
      por_pend_q <= 1'b1;
      armed_q    <= 1'b0;
      pf_done_q  <= 1'b0;
      busy       <= 1'b1;
      status_n   <= 1'b1;
      done       <= 1'b0;
    end else begin
      st_q       <= st_nxt;
      por_pend_q <= pend_nxt;
      if (start) dir_q <= sel_dir;
      // Arm commands act only when the device is free to accept them.
      if (pwr_up_rst)                   armed_q <= 1'b0;
      else if (allow && !por_pend_q) begin
        if (arm_clr)                    armed_q <= 1'b0;
        else if (arm_set)               armed_q <= 1'b1;
      end
      if (!supply_low)   pf_done_q <= 1'b0;
      else if (take_pf)  pf_done_q <= 1'b1;
      busy     <= (st_nxt != ST_IDLE) || pend_nxt || lockout;
      status_n <= !supply_low;
      done     <= (st_q == ST_HOLD) && expire;
    end
  end

  assign xfer_dir = dir_q;
endmodule

// File: rtl/nv_xfer_ctrl_chk.sv
module nv_xfer_ctrl_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              supply_low,
  input logic              lockout,
  input logic              busy,
  input logic              status_n,
  input logic              xfer_stb,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              xfer_dir,
  input logic              done
);
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && $past(xfer_stb) && !$past(rst)) |-> (xfer_addr == $past(xfer_addr) + 1'b1));

  assert_dir_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (xfer_stb && $past(xfer_stb) && !$past(rst)) |-> $stable(xfer_dir));

  assert_first_addr_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_stb) |-> (xfer_addr == '0));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> busy);

  assert_status_follow_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_n == !$past(supply_low)));

  assert_no_start_locked_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(xfer_stb) && !$past(rst)) |-> !$past(lockout));

  assert_lock_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lockout)) |-> busy);
endmodule

bind nv_xfer_ctrl nv_xfer_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .supply_low (supply_low),
  .lockout    (lockout),
  .busy       (busy),
  .status_n   (status_n),
  .xfer_stb   (xfer_stb),
  .xfer_addr  (xfer_addr),
  .xfer_dir   (xfer_dir),
  .done       (done)
);

// File: tb/nv_xfer_ctrl_tb_top.sv
module nv_xfer_ctrl_tb_top;
  localparam int AW    = 4;
  localparam int WORDS = 1 << AW;
  localparam int RH    = 3;
  localparam int SH    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_up_rst = 0, supply_low = 0, lockout = 0;
  logic store_req = 0, recall_req = 0, arm_set = 0, arm_clr = 0;
  logic busy, status_n, xfer_stb, xfer_dir, done;
  logic [AW-1:0] xfer_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nv_xfer_ctrl #(.ADDR_W(AW), .RECALL_HOLD(RH), .STORE_HOLD(SH)) dut_i (
    .clk(clk), .rst(rst), .pwr_up_rst(pwr_up_rst), .supply_low(supply_low),
    .lockout(lockout), .store_req(store_req), .recall_req(recall_req),
    .arm_set(arm_set), .arm_clr(arm_clr), .busy(busy), .status_n(status_n),
    .xfer_stb(xfer_stb), .xfer_addr(xfer_addr), .xfer_dir(xfer_dir), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (xfer_stb) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  // Called on the first falling edge after the start edge.
  // poke: cycle index at which ignored requests are driven (-1 = none).
  task automatic run_xfer(input int dir, input int hold, input string req, input int poke);
    int n = 0, s = 0, bad = 0;
    check(xfer_stb == 1'b1 && xfer_addr == '0, req, xfer_stb, 1);
    check(xfer_dir == dir[0], req, xfer_dir, dir);
    while (busy && n < 10000) begin
      if (xfer_stb) begin
        if (xfer_addr != s[AW-1:0]) bad++;
        s++;
      end
      if (xfer_dir != dir[0]) bad++;
      if (n == poke) begin store_req = 1; recall_req = 1; arm_set = 1; end
      if (n == poke + 1) begin store_req = 0; recall_req = 0; arm_set = 0; end
      n++;
      @(negedge clk);
    end
    check(bad == 0, "R2 address walk", bad, 0);
    check(s == WORDS, "R2 strobe count", s, WORDS);
    check(n == WORDS + hold, {req, " R3 busy length"}, n, WORDS + hold);
    check(done == 1'b1, "R3 done at end", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R3 done one cycle", done, 0);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic t_reset_por();
    repeat (3) @(negedge clk);
    check(busy == 1 && status_n == 1 && xfer_stb == 0 && done == 0, "R1 reset state",
          {busy, status_n, xfer_stb, done}, 4'b1100);
    rst = 1'b0;
    @(negedge clk);
    run_xfer(0, RH, "R1 power-on recall", -1);
    check(busy == 1'b0, "R1 busy released", busy, 0);
  endtask

  task automatic t_sw_store();
    pulse(store_req);
    run_xfer(1, SH, "R4 software store", -1);
  endtask

  task automatic t_host_recall();
    pulse(recall_req);
    run_xfer(0, RH, "R5 host recall", -1);
  endtask

  task automatic t_priority();
    store_req = 1; recall_req = 1;
    @(negedge clk);
    store_req = 0; recall_req = 0;
    run_xfer(1, SH, "R11 store over recall", -1);
  endtask

  task automatic t_powerfail();
    pulse(arm_set);
    @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    check(status_n == 1'b0, "R7 status low", status_n, 0);
    run_xfer(1, SH, "R6 power-fail store", -1);
    idle_quiet(8, "R6 one store per episode");
    supply_low = 1'b0;
    @(negedge clk);
    check(status_n == 1'b1, "R7 status high", status_n, 1);
    pulse(arm_clr);
    supply_low = 1'b1;
    @(negedge clk);
    check(status_n == 1'b0, "R7 status unarmed", status_n, 0);
    idle_quiet(8, "R6 disarmed no store");
    supply_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_lockout();
    lockout = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy under lockout", busy, 1);
    pulse(recall_req);
    pulse(store_req);
    idle_quiet(4, "R8 no start under lockout");
    lockout = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && xfer_stb == 1'b0, "R8 request not remembered", busy, 0);
    idle_quiet(4, "R8 still idle");
    lockout = 1'b1;
    pulse(pwr_up_rst);
    idle_quiet(4, "R8 owed recall held");
    lockout = 1'b0;
    @(negedge clk);
    run_xfer(0, RH, "R8 owed recall after lockout", -1);
  endtask

  task automatic t_busy_ignores();
    pulse(store_req);
    run_xfer(1, SH, "R9 store with pokes", 5);
    idle_quiet(6, "R9 requests not queued");
    supply_low = 1'b1;
    idle_quiet(6, "R9 arm ignored while busy");
    supply_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_pwrup();
    pulse(arm_set);
    pwr_up_rst = 1'b1;
    @(negedge clk);
    pwr_up_rst = 1'b0;
    check(busy == 1'b1 && xfer_stb == 1'b0, "R10 recall owed", busy, 1);
    @(negedge clk);
    run_xfer(0, RH, "R10 power-up recall", -1);
    supply_low = 1'b1;
    idle_quiet(6, "R10 latch disarmed");
    supply_low = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset_por();
    t_sw_store();
    t_host_recall();
    t_priority();
    t_powerfail();
    t_lockout();
    t_busy_ignores();
    t_pwrup();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule